// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block chooses which frame of a small, fully associative store of `NUM_FRAMES` frames is to be refilled when a page fault occurs. It applies the second-chance clock policy. Every frame carries a resident flag, a use bit and a dirty bit, and a single circular hand points at the frame to be examined next. Memory references come in on the access port. Each one marks a resident frame as recently used, and a write reference also marks it dirty.

A fault request arrives through a valid/ready handshake. The request is taken in a cycle where both `flt_valid` and `flt_ready` are high. While a sweep runs, `flt_ready` stays low and a held `flt_valid` waits. When the sweep ends, the block pulses `victim_valid` for one cycle. With that pulse it gives the chosen frame index, whether a resident page is being evicted, and whether that page was dirty, so that a controller can schedule a write-back. The victim output has no back-pressure and is valid only during its pulse.

The chosen frame is marked resident again, with its use and dirty bits cleared, and the hand moves one frame past it. The hand therefore rests on the oldest resident page. While empty frames exist, faults fill them in index order without evicting anything.

Top module: `clock_victim_sel`

## Requirements
- R1: After synchronous reset, `busy` is 0, `flt_ready` is 1 and `victim_valid` is 0. No frame is resident and the hand is at frame 0.
- R2: Starting from reset, the first `NUM_FRAMES` faults fill frames 0, 1, 2, … in order. Each reports `victim_evict`=0 and `victim_dirty`=0, and each ends one clock after its handshake (victim_valid high in the cycle after the next edge).
- R3: An access to a resident frame sets its use bit. An access (read or write) to a frame that is not resident changes nothing.
- R4: During a sweep, one frame is examined per clock at the hand. A set use bit is cleared, that frame is skipped and the hand advances. The first frame found with a clear use bit becomes the victim. If k frames are skipped, `victim_valid` rises k+1 clocks after the handshake edge.
- R5: The hand advances only during sweeps, and it wraps from frame `NUM_FRAMES`-1 to frame 0.
- R6: If all use bits are set, the sweep clears all of them in one revolution and picks the frame where it started, `NUM_FRAMES`+1 clocks after the handshake.
- R7: A refilled frame is resident with a clear use bit, and the hand then points at the following frame. `victim_evict`=1 when the chosen frame held a page.
- R8: `flt_ready` equals the inverse of `busy`. `busy` is high from the clock after the handshake up to the edge where `victim_valid` rises, and `victim_valid` is a single-cycle pulse.
- R9: Accesses arriving during a sweep still set use bits. When an access and a sweep clear hit the same frame in the same clock, the use bit stays set.
- R10: A write access (`acc_write`=1) sets the frame's dirty bit. The bit is reported as `victim_dirty` when that frame is chosen and is cleared by the refill. A skip does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | A frame reference is present this cycle |
| acc_idx | input | IDX_W | Frame index referenced |
| acc_write | input | 1 | Reference is a write (marks dirty) |
| flt_valid | input | 1 | Fault request valid |
| flt_ready | output | 1 | Block can accept a fault request |
| busy | output | 1 | Sweep in progress |
| victim_valid | output | 1 | One-cycle pulse: victim fields are valid |
| victim_idx | output | IDX_W | Chosen frame |
| victim_evict | output | 1 | Chosen frame held a resident page |
| victim_dirty | output | 1 | Evicted page was written |

## Verification
A wrong hand position or a lost use bit shows up at the next fault as a different `victim_idx` or a different sweep length. The sweep length is measured in clocks from the handshake to `victim_valid`, so a single misplaced clear shifts the result by one cycle at once. A dirty bit that is dropped or kept wrongly is only visible when that frame is next chosen, so the sequences revisit every written frame. A stale resident flag appears on the first revolution as an unexpected `victim_evict` value or a skipped empty frame.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic {ST_IDLE, ST_SWEEP} sweep_state_e;
endpackage

// File: rtl/cvs_frame_bits.sv
module cvs_frame_bits #(
  parameter int NUM_FRAMES = 4,
  parameter int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_idx,
  input  logic                  acc_write,
  input  logic                  clr_en,
  input  logic                  fill_en,
  input  logic [IDX_W-1:0]      sel_idx,
  output logic [NUM_FRAMES-1:0] use_vec,
  output logic [NUM_FRAMES-1:0] valid_vec,
  output logic [NUM_FRAMES-1:0] dirty_vec
);
  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
    logic hit, sel;
    assign hit = acc_valid && (acc_idx == IDX_W'(i)) && valid_vec[i];
    assign sel = (sel_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        use_vec[i]   <= 1'b0;
        valid_vec[i] <= 1'b0;
        dirty_vec[i] <= 1'b0;
      end else begin
        if (hit)                         use_vec[i] <= 1'b1;
        else if ((clr_en || fill_en) && sel) use_vec[i] <= 1'b0;
        if (fill_en && sel)              valid_vec[i] <= 1'b1;
        if (hit && acc_write)            dirty_vec[i] <= 1'b1;
        else if (fill_en && sel)         dirty_vec[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cvs_sweep_ctrl.sv
module cvs_sweep_ctrl
  import cvs_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flt_valid,
  input  logic [NUM_FRAMES-1:0] use_vec,
  input  logic [NUM_FRAMES-1:0] valid_vec,
  input  logic [NUM_FRAMES-1:0] dirty_vec,
  output logic                  flt_ready,
  output logic                  busy,
  output logic                  clr_en,
  output logic                  fill_en,
  output logic [IDX_W-1:0]      hand,
  output logic                  victim_valid,
  output logic [IDX_W-1:0]      victim_idx,
  output logic                  victim_evict,
  output logic                  victim_dirty
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  sweep_state_e state;
  logic         take;
  logic [IDX_W-1:0] hand_nxt;

  assign busy      = (state == ST_SWEEP);
  assign flt_ready = !busy;
  assign take      = (!valid_vec[hand]) || (!use_vec[hand]);
  assign clr_en    = busy && !take;
  assign fill_en   = busy && take;
  assign hand_nxt  = (hand == LAST) ? '0 : hand + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      hand         <= '0;
      victim_valid <= 1'b0;
      victim_idx   <= '0;
      victim_evict <= 1'b0;
      victim_dirty <= 1'b0;
    end else begin
      victim_valid <= 1'b0;
      case (state)
        ST_IDLE: if (flt_valid) state <= ST_SWEEP;
        ST_SWEEP: begin
          hand <= hand_nxt;
          if (take) begin
            state        <= ST_IDLE;
            victim_valid <= 1'b1;
            victim_idx   <= hand;
            victim_evict <= valid_vec[hand];
            victim_dirty <= valid_vec[hand] && dirty_vec[hand];
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_FRAMES = 4,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             acc_write,
  input  logic             flt_valid,
  output logic             flt_ready,
  output logic             busy,
  output logic             victim_valid,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_evict,
  output logic             victim_dirty
);
  logic [NUM_FRAMES-1:0] use_vec, valid_vec, dirty_vec;
  logic                  clr_en, fill_en;
  logic [IDX_W-1:0]      hand;

  cvs_frame_bits #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_bits (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_write(acc_write),
    .clr_en(clr_en), .fill_en(fill_en), .sel_idx(hand),
    .use_vec(use_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec)
  );

  cvs_sweep_ctrl #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .flt_valid(flt_valid),
    .use_vec(use_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
    .flt_ready(flt_ready), .busy(busy), .clr_en(clr_en), .fill_en(fill_en),
    .hand(hand), .victim_valid(victim_valid), .victim_idx(victim_idx),
    .victim_evict(victim_evict), .victim_dirty(victim_dirty)
  );
endmodule

// File: rtl/cvs_checker.sv
module cvs_checker #(
  parameter int NUM_FRAMES = 4,
  parameter int IDX_W = $clog2(NUM_FRAMES)
) (
  input logic             clk,
  input logic             rst,
  input logic             flt_valid,
  input logic             flt_ready,
  input logic             busy,
  input logic             victim_valid,
  input logic [IDX_W-1:0] victim_idx,
  input logic             victim_evict,
  input logic             victim_dirty
);
  int sweep_len;
  always_ff @(posedge clk) begin
    if (rst || !busy) sweep_len <= 0;
    else              sweep_len <= sweep_len + 1;
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && flt_ready) |=> busy); // R8
  AST_END_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> victim_valid); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    victim_valid |=> !victim_valid); // R8
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    victim_valid |-> (int'(victim_idx) < NUM_FRAMES)); // R5
  AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (sweep_len < NUM_FRAMES + 1)); // R6
  AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (victim_valid && !victim_evict) |-> !victim_dirty); // R10
endmodule

bind clock_victim_sel cvs_checker #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_ready(flt_ready),
  .busy(busy), .victim_valid(victim_valid), .victim_idx(victim_idx),
  .victim_evict(victim_evict), .victim_dirty(victim_dirty)
);

// File: tb/sim_clock_victim_sel.sv
`timescale 1ns/1ps
module sim_clock_victim_sel;
  localparam int N = 4;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0, acc_write = 1'b0, flt_valid = 1'b0;
  logic [W-1:0] acc_idx = '0;
  logic flt_ready, busy, victim_valid, victim_evict, victim_dirty;
  logic [W-1:0] victim_idx;

  always #2.5 clk = ~clk;

  clock_victim_sel #(.NUM_FRAMES(N)) u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .acc_write(acc_write), .flt_valid(flt_valid), .flt_ready(flt_ready),
    .busy(busy), .victim_valid(victim_valid), .victim_idx(victim_idx),
    .victim_evict(victim_evict), .victim_dirty(victim_dirty)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_access(input int idx, input bit wr);
    @(negedge clk); acc_valid = 1; acc_idx = W'(idx); acc_write = wr;
    @(negedge clk); acc_valid = 0; acc_write = 0;
  endtask

  // Fault; optional access presented on the first sweep clock.
  task automatic do_fault(input bit side, input int sidx,
                          output int vi, output int vd, output int ve, output int lat);
    @(negedge clk);
    check(flt_ready == 1, "R8 ready before fault", flt_ready, 1);
    flt_valid = 1;
    @(posedge clk);
    @(negedge clk); flt_valid = 0;
    check(busy == 1 && flt_ready == 0, "R8 busy after handshake", busy, 1);
    if (side) begin acc_valid = 1; acc_idx = W'(sidx); acc_write = 0; end
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); lat++;
      @(negedge clk); acc_valid = 0;
      if (victim_valid) break;
    end
    vi = victim_idx; vd = victim_dirty; ve = victim_evict;
    check(busy == 0 && flt_ready == 1, "R8 idle at victim pulse", busy, 0);
  endtask

  // Vector: op(1=fault) idx wr | exp victim, dirty, evict, latency
  typedef struct packed {
    logic       op; logic [1:0] idx; logic wr;
    logic [1:0] ev; logic ed; logic ee; logic [3:0] lat;
  } vec_t;
  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{1'b0, 2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 4'd0}, // R3 non-resident write ignored
    '{1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd1}, // R2 fill 0
    '{1'b1, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 4'd1}, // R2 fill 1
    '{1'b1, 2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 4'd1}, // R2 fill 2, clean (R3)
    '{1'b0, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 4'd0},
    '{1'b1, 2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 4'd1}, // R2 fill 3, hand wraps R5
    '{1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0},
    '{1'b0, 2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 4'd0},
    '{1'b1, 2'd0, 1'b0, 2'd3, 1'b0, 1'b1, 4'd4}, // R4 skip 0,1,2
    '{1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 4'd1}, // R5 wrapped to 0
    '{1'b1, 2'd0, 1'b0, 2'd1, 1'b1, 1'b1, 4'd1}, // R10 dirty survives skip
    '{1'b1, 2'd0, 1'b0, 2'd2, 1'b1, 1'b1, 4'd1}, // R10
    '{1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0},
    '{1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0},
    '{1'b0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0},
    '{1'b0, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 4'd0},
    '{1'b1, 2'd0, 1'b0, 2'd3, 1'b1, 1'b1, 4'd5}, // R6 full revolution from 3
    '{1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 4'd1}  // R7 refilled 3 clean, hand 0
  };

  initial begin
    int vi, vd, ve, lat;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(flt_ready == 1, "R1 ready after reset", flt_ready, 1);
    check(victim_valid == 0, "R1 no victim after reset", victim_valid, 0);

    for (int v = 0; v < NV; v++) begin
      if (!VT[v].op) do_access(VT[v].idx, VT[v].wr);
      else begin
        do_fault(0, 0, vi, vd, ve, lat);
        check(vi == VT[v].ev, "R4 victim index", vi, VT[v].ev);
        check(vd == VT[v].ed, "R10 victim dirty", vd, VT[v].ed);
        check(ve == VT[v].ee, "R7 victim evict", ve, VT[v].ee);
        check(lat == VT[v].lat, "R4 sweep latency", lat, VT[v].lat);
      end
    end

    // R9: access to frame 1 in the same clock it is cleared keeps its use bit.
    do_access(1, 0);
    do_access(2, 0);
    do_fault(1, 1, vi, vd, ve, lat);
    check(vi == 3, "R9 victim with concurrent access", vi, 3);
    check(lat == 3, "R9 latency", lat, 3);
    do_fault(0, 0, vi, vd, ve, lat);
    check(vi == 0 && lat == 1, "R7 oldest page next", vi, 0);
    do_fault(0, 0, vi, vd, ve, lat);
    check(vi == 2, "R9 access won over clear", vi, 2);
    check(lat == 2, "R9 frame 1 skipped", lat, 2);

    // R1: reset mid-run returns to empty; first fault fills frame 0.
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    do_fault(0, 0, vi, vd, ve, lat);
    check(vi == 0 && ve == 0, "R1 hand and residency reset", vi, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule